// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Mode-Split Write Protection

This block translates virtual page numbers to physical page numbers for a RISC core. It holds a small, fully associative set of entries, and only privileged software fills them. No hardware table walker exists. The core presents a request only for jumps, calls, loads and stores. One cycle later the block returns the physical address, or it raises a trap.

There are two trap reasons:
- **Miss.** No valid entry matches both the page tag and the process identifier. Software then reloads an entry and retries.
- **Write protection.** A store hits an entry whose write-protect bit for the current privilege mode is set. Each entry has one such bit for supervisor mode and one for user mode.

On a trap, the block latches the faulting virtual address and a cause code into status outputs. Entries carry no referenced or modified state. Lookups never change an entry, so replacing an entry is a plain overwrite.

Software writes one whole entry in a single cycle through a write port. It can also clear every valid bit at once. With the default parameters the block has 16 entries, a 32-bit virtual address, 4 KiB pages, a 20-bit page tag, an 8-bit process identifier and a 20-bit physical page number.

Top module: `sw_tlb`

## Requirements
- R1: After reset, no entry is valid, `rsp_valid` and `rsp_trap` are 0, `fault_cause` is 00 and `fault_addr` is 0.
- R2: A request presented in cycle N is answered in cycle N+1 with `rsp_valid`=1. On a hit, `rsp_paddr` is the entry's physical page number concatenated with the 12-bit page offset of the request.
- R3: A request that matches no valid entry gives `rsp_hit`=0 and `rsp_trap`=1. In the same cycle `fault_cause` becomes 01 and `fault_addr` becomes the request's virtual address.
- R4: A hit requires both the 20-bit tag and the 8-bit process identifier to match. A tag match with a different identifier is a miss.
- R5: The request kind is encoded as 00 jump, 01 call, 10 load and 11 store. A store that hits an entry with the write-protect bit for the current mode set gives `rsp_hit`=1 and `rsp_trap`=1, and sets `fault_cause` to 10 with `fault_addr` set to the address. `req_user`=1 selects the user bit and `req_user`=0 selects the supervisor bit. Jumps, calls and loads never take a protection trap.
- R6: An entry written in cycle N is seen by lookups from cycle N+1 on. A lookup in cycle N sees the previous contents.
- R7: Asserting `inval_all` for one cycle clears every valid bit, so every later lookup misses until entries are written again.
- R8: When several valid entries match, the lowest-numbered entry supplies the translation and its protect bits.
- R9: `fault_addr` and `fault_cause` change only on a trap. Lookups never alter entries, so a repeated lookup gives the same result.
- R10: In a cycle after no request, `rsp_valid` and `rsp_trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_kind | input | 2 | 00 jump, 01 call, 10 load, 11 store |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_vaddr | input | 32 | Virtual address |
| req_asid | input | 8 | Current process identifier |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 20 | Virtual page tag |
| wr_asid | input | 8 | Process identifier of the entry |
| wr_ppn | input | 20 | Physical page number |
| wr_valid | input | 1 | Valid bit of the entry |
| wr_wp_sup | input | 1 | Supervisor write-protect bit |
| wr_wp_usr | input | 1 | User write-protect bit |
| inval_all | input | 1 | Clear every valid bit |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | A matching valid entry was found |
| rsp_trap | output | 1 | Miss or write-protection trap |
| rsp_paddr | output | 32 | Translated physical address (valid on hit) |
| fault_addr | output | 32 | Virtual address of the last trap |
| fault_cause | output | 2 | 01 miss, 10 write protection, 00 none since reset |

## Verification
Some behaviours are checked by assertions on every cycle:
- the one-cycle response timing;
- that traps only accompany responses;
- that a miss always carries cause 01 and latches the request address;
- that the status outputs stay put without a trap;
- that non-store kinds never take a protection trap.

Other behaviours only the bench's scenarios can show, since they depend on entry contents written earlier:
- the actual translated addresses;
- the choice between the supervisor and user protect bits;
- lowest-index priority among duplicates;
- identifier mismatch;
- write-to-lookup visibility;
- the effect of invalidate-all.

// File: rtl/sw_tlb.sv
module sw_tlb #(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ASID_W    = 8,
  parameter int PPN_W     = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [1:0]                    req_kind,
  input  logic                          req_user,
  input  logic [VA_W-1:0]               req_vaddr,
  input  logic [ASID_W-1:0]             req_asid,
  input  logic                          wr_en,
  input  logic [$clog2(ENTRIES)-1:0]    wr_idx,
  input  logic [VA_W-PAGE_BITS-1:0]     wr_vpn,
  input  logic [ASID_W-1:0]             wr_asid,
  input  logic [PPN_W-1:0]              wr_ppn,
  input  logic                          wr_valid,
  input  logic                          wr_wp_sup,
  input  logic                          wr_wp_usr,
  input  logic                          inval_all,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic                          rsp_trap,
  output logic [PPN_W+PAGE_BITS-1:0]    rsp_paddr,
  output logic [VA_W-1:0]               fault_addr,
  output logic [1:0]                    fault_cause
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [1:0] KIND_STORE  = 2'b11;
  localparam logic [1:0] CAUSE_MISS  = 2'b01;
  localparam logic [1:0] CAUSE_WPROT = 2'b10;

  logic [ENTRIES-1:0] ent_v, ent_wps, ent_wpu, match;
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [ASID_W-1:0]  ent_asid [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_v <= '0;
    else begin
      if (inval_all) ent_v <= '0;
      if (wr_en) ent_v[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_vpn[wr_idx]  <= wr_vpn;
      ent_asid[wr_idx] <= wr_asid;
      ent_ppn[wr_idx]  <= wr_ppn;
      ent_wps[wr_idx]  <= wr_wp_sup;
      ent_wpu[wr_idx]  <= wr_wp_usr;
    end
  end

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:PAGE_BITS];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = ent_v[i] && ent_vpn[i] == req_vpn && ent_asid[i] == req_asid;
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  wire hit  = |match;
  wire wp   = req_user ? ent_wpu[sel] : ent_wps[sel];
  wire prot = hit && req_kind == KIND_STORE && wp;
  wire trap = req_valid && (!hit || prot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_trap    <= 1'b0;
      rsp_paddr   <= '0;
      fault_addr  <= '0;
      fault_cause <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit;
      rsp_trap  <= trap;
      rsp_paddr <= hit ? {ent_ppn[sel], req_vaddr[PAGE_BITS-1:0]} : '0;
      if (trap) begin
        fault_addr  <= req_vaddr;
        fault_cause <= hit ? CAUSE_WPROT : CAUSE_MISS;
      end
    end
  end
endmodule

module sw_tlb_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_kind,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_trap,
  input logic [VA_W-1:0] fault_addr,
  input logic [1:0]      fault_cause
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_trap); // R10
  AST_TRAP_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_valid); // R10
  AST_MISS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_trap && fault_cause == 2'b01); // R3
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !rsp_trap || fault_addr == $past(req_vaddr)); // R3
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_trap |-> $stable(fault_addr) && $stable(fault_cause)); // R9
  AST_NONSTORE_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind != 2'b11 |=> !(rsp_hit && rsp_trap)); // R5
endmodule

bind sw_tlb sw_tlb_chk #(.VA_W(VA_W)) chk_i (.*);

// File: tb/sw_tlb_tb.sv
module sw_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_user = 0;
  logic [1:0]  req_kind = 0;
  logic [31:0] req_vaddr = 0;
  logic [7:0]  req_asid = 0;
  logic        wr_en = 0, wr_valid = 0, wr_wp_sup = 0, wr_wp_usr = 0, inval_all = 0;
  logic [3:0]  wr_idx = 0;
  logic [19:0] wr_vpn = 0, wr_ppn = 0;
  logic [7:0]  wr_asid = 0;
  logic        rsp_valid, rsp_hit, rsp_trap;
  logic [31:0] rsp_paddr, fault_addr;
  logic [1:0]  fault_cause;

  int checks = 0, fails = 0;
  logic [31:0] exp_fa = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_tlb dut_i (.*);

  // {kind, user, vaddr, asid, exp_trap, exp_hit, exp_paddr, exp_cause}
  localparam logic [78:0] VEC [NV] = '{
    {2'd2, 1'b1, 32'h12345678, 8'h07, 1'b0, 1'b1, 32'hABCDE678, 2'b01},
    {2'd3, 1'b1, 32'h12345ABC, 8'h07, 1'b1, 1'b1, 32'hABCDEABC, 2'b10},
    {2'd3, 1'b0, 32'h12345000, 8'h07, 1'b0, 1'b1, 32'hABCDE000, 2'b10},
    {2'd3, 1'b0, 32'h00400FFF, 8'h07, 1'b1, 1'b1, 32'h11111FFF, 2'b10},
    {2'd3, 1'b1, 32'h00400010, 8'h07, 1'b0, 1'b1, 32'h11111010, 2'b10},
    {2'd0, 1'b1, 32'h00400020, 8'h09, 1'b0, 1'b1, 32'h22222020, 2'b10},
    {2'd1, 1'b0, 32'h00400020, 8'h03, 1'b1, 1'b0, 32'h00000000, 2'b01},
    {2'd2, 1'b1, 32'hDEADB004, 8'h07, 1'b1, 1'b0, 32'h00000000, 2'b01}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_entry(input logic [3:0] idx, input logic [19:0] vpn, input logic [7:0] asid,
                           input logic [19:0] ppn, input logic wps, input logic wpu);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn;
    wr_valid = 1; wr_wp_sup = wps; wr_wp_usr = wpu;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input logic [1:0] kind, input logic user, input logic [31:0] va, input logic [7:0] asid);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_user = user; req_vaddr = va; req_asid = asid;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !rsp_trap, "R1 rsp idle in reset", {30'd0, rsp_valid, rsp_trap}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(fault_cause == 2'b00 && fault_addr == 0, "R1 status cleared", fault_addr, 0);
    lookup(2'd2, 1'b0, 32'h00000123, 8'h00);
    chk(rsp_valid && !rsp_hit && rsp_trap, "R1 R3 empty buffer misses", {29'd0, rsp_valid, rsp_hit, rsp_trap}, 32'd5);
    chk(fault_cause == 2'b01 && fault_addr == 32'h00000123, "R3 miss status", fault_addr, 32'h123);
    exp_fa = 32'h00000123;
    @(negedge clk);
    chk(!rsp_valid && !rsp_trap, "R10 no request no response", {30'd0, rsp_valid, rsp_trap}, 0);

    put_entry(4'd3, 20'h12345, 8'h07, 20'hABCDE, 1'b0, 1'b1);
    put_entry(4'd5, 20'h00400, 8'h07, 20'h11111, 1'b1, 1'b0);
    put_entry(4'd9, 20'h12345, 8'h07, 20'h55555, 1'b0, 1'b0);
    put_entry(4'd0, 20'h00400, 8'h09, 20'h22222, 1'b0, 1'b0);

    // R2 R4 R5 R8 R9 table walk
    for (int k = 0; k < NV; k++) begin
      lookup(VEC[k][78:77], VEC[k][76], VEC[k][75:44], VEC[k][43:36]);
      if (VEC[k][35]) exp_fa = VEC[k][75:44];
      chk(rsp_valid && rsp_trap == VEC[k][35] && rsp_hit == VEC[k][34],
          $sformatf("R2 R4 R5 vec%0d hit/trap", k), {30'd0, rsp_hit, rsp_trap}, {30'd0, VEC[k][34], VEC[k][35]});
      if (VEC[k][34])
        chk(rsp_paddr == VEC[k][33:2], $sformatf("R2 R8 vec%0d paddr", k), rsp_paddr, VEC[k][33:2]);
      chk(fault_cause == VEC[k][1:0] && fault_addr == exp_fa,
          $sformatf("R3 R5 R9 vec%0d status", k), fault_addr, exp_fa);
    end

    lookup(2'd2, 1'b1, 32'h12345678, 8'h07);
    chk(rsp_hit && rsp_paddr == 32'hABCDE678, "R9 repeat lookup unchanged", rsp_paddr, 32'hABCDE678);

    // R6 same-cycle write is not seen, next cycle is
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd7; wr_vpn = 20'h0ABCD; wr_asid = 8'h07; wr_ppn = 20'h77777;
    wr_valid = 1; wr_wp_sup = 0; wr_wp_usr = 0;
    req_valid = 1; req_kind = 2'd2; req_user = 1; req_vaddr = 32'h0ABCD044; req_asid = 8'h07;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk(!rsp_hit && rsp_trap, "R6 same-cycle write unseen", {31'd0, rsp_hit}, 0);
    lookup(2'd2, 1'b1, 32'h0ABCD044, 8'h07);
    chk(rsp_hit && !rsp_trap && rsp_paddr == 32'h77777044, "R6 write seen next cycle", rsp_paddr, 32'h77777044);

    // R7 invalidate-all
    @(negedge clk);
    inval_all = 1;
    @(negedge clk);
    inval_all = 0;
    lookup(2'd2, 1'b1, 32'h12345678, 8'h07);
    chk(!rsp_hit && rsp_trap && fault_cause == 2'b01, "R7 entry 3 cleared", {31'd0, rsp_hit}, 0);
    lookup(2'd0, 1'b0, 32'h00400020, 8'h09);
    chk(!rsp_hit && rsp_trap, "R7 entry 0 cleared", {31'd0, rsp_hit}, 0);
    lookup(2'd2, 1'b1, 32'h0ABCD044, 8'h07);
    chk(!rsp_hit && fault_addr == 32'h0ABCD044, "R7 entry 7 cleared", fault_addr, 32'h0ABCD044);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule